// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a synthesizable behavioural model of a synchronous static RAM with a pipelined read path and a short built-in burst engine. Each word is 36 bits wide and is split into four 9-bit byte lanes. The depth is set by an address-width parameter. Every input is captured on the rising clock edge. A cycle is then decoded from the captured values and from the state of the burst in progress.

A burst opens on one of two active-low address strobes. The first strobe always opens a read. The second strobe opens a read or a write, as the write controls decide. Once a burst is open, cycles with neither strobe continue it: an active-low step input moves the 2-bit burst field to its next value, and a cycle without the step input repeats the current word. The burst order is chosen when the burst opens, either a wrapping increment or an XOR pattern. Writes can update all lanes at once or only chosen lanes. Three active-low selects must all be low for the device to take part. Read data leaves through an output register. When the device is deselected, the output keeps its last value for one further slot and only then turns off, and an enable flag reports whether the output is driven.

Top module: `burst_sram`

## Requirements
- R1: Read data for a read command captured at edge k is on `rdata` after edge k+2, with `rdata_oe` high. A write issued earlier is visible to every later read.
- R2: `strb_proc_n` low, with all three selects low, opens a burst at `addr` and is always a read, whatever the write controls say.
- R3: `strb_proc_n` is ignored while any select is high. That cycle is then decoded from `strb_ctl_n`, or as a continuation of the open burst.
- R4: When both strobes are low in one cycle with all selects low, the `strb_proc_n` read wins and nothing is written.
- R5: `strb_ctl_n` low, with all selects low and `strb_proc_n` ignored or high, opens a burst at `addr`. It is a write when the lane mask (R9, R10) is non-zero and a read otherwise.
- R6: In a continuation cycle (both strobes high, burst open), `step_n` low advances the 2-bit count by one before the access. `step_n` high repeats the current address.
- R7: With `order_ilv` low when the burst opens, the low two address bits are (start + count) mod 4. Address bits 2 and up stay at their start value.
- R8: With `order_ilv` high when the burst opens, the low two address bits are start XOR count, where count runs 0, 1, 2, 3.
- R9: With `wr_all_n` high and `lane_wr_en_n` low, lane i (bits 9i+8 down to 9i) is written only when `lane_sel_n[i]` is low. With `lane_wr_en_n` high, the lane selects are ignored and the cycle is a read.
- R10: `wr_all_n` low writes all four lanes, whatever `lane_wr_en_n` and `lane_sel_n` are set to.
- R11: `strb_ctl_n` low with any select high closes the burst. The first deselect slot after a driven read keeps `rdata` and `rdata_oe`. The second consecutive deselect slot drives `rdata_oe` low. Write slots drive `rdata_oe` low.
- R12: While `rst` is high, the outputs go to `rdata_oe` = 0 and `rdata` = 0, and no burst is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | AW | Word address |
| wdata | input | 36 | Write data, captured with the write command |
| strb_proc_n | input | 1 | Read-only burst-open strobe, active low |
| strb_ctl_n | input | 1 | Read/write burst-open strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Write all lanes, active low |
| lane_wr_en_n | input | 1 | Qualifies the lane selects, active low |
| lane_sel_n | input | 4 | Per-lane write select, active low |
| order_ilv | input | 1 | 0 = wrapping increment, 1 = XOR order |
| sel0_n | input | 1 | Device select, active low |
| sel1_n | input | 1 | Device select, active low |
| sel2_n | input | 1 | Device select, active low |
| rdata | output | 36 | Registered read data |
| rdata_oe | output | 1 | High while rdata is driven |

## Verification
Several properties are checked on every cycle:
- the two-slot read latency after a read-only burst open, including when write controls are asserted alongside it;
- the output turning off two slots after a write;
- the one-slot hold of the output after a read followed by a deselect;
- the turn-off after two deselects in a row;
- the reset values.

Data correctness needs the bench's reference array. This covers the address order for every start address in both orders, lane merging for every mask, the override by the write-all input, and the ignored strobe. Only the bench's scenarios can show these.

// File: rtl/sram_pkg.sv
package sram_pkg;

    parameter int unsigned LANES  = 4;
    parameter int unsigned LANE_W = 9;
    parameter int unsigned DW     = LANES * LANE_W;
    parameter int unsigned CNT_W  = 2;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    typedef struct packed {
        logic             p_n;
        logic             c_n;
        logic             step_n;
        logic             all_n;
        logic             lane_en_n;
        logic [LANES-1:0] lane_n;
        logic             ilv;
        logic [2:0]       sel_n;
    } ctl_t;

    localparam ctl_t CTL_IDLE = '{p_n: 1'b1, c_n: 1'b1, step_n: 1'b1, all_n: 1'b1,
                                  lane_en_n: 1'b1, lane_n: '1, ilv: 1'b0,
                                  sel_n: 3'b111};

    function automatic logic [CNT_W-1:0] burst_low(input logic [CNT_W-1:0] start,
                                                   input logic [CNT_W-1:0] cnt,
                                                   input logic             ilv);
        return ilv ? (start ^ cnt) : CNT_W'(start + cnt);
    endfunction

    function automatic logic [LANES-1:0] lane_mask(input logic             all_n,
                                                   input logic             lane_en_n,
                                                   input logic [LANES-1:0] lane_n);
        if (!all_n)          return '1;
        else if (!lane_en_n) return ~lane_n;
        else                 return '0;
    endfunction

endpackage

// File: rtl/sram_ctrl.sv
module sram_ctrl
    import sram_pkg::*;
#(
    parameter int unsigned AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  ctl_t          ctl_in,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] wdata_in,
    output op_e           op,
    output logic [AW-1:0] op_addr,
    output logic [LANES-1:0] op_mask,
    output logic [DW-1:0] op_wdata
);

    ctl_t              ctl_q;
    logic [AW-1:0]     addr_q;
    logic [DW-1:0]     wdata_q;

    logic              act_q, act_d;
    logic [AW-1:0]     base_q, base_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              ilv_q, ilv_d;

    logic              sel_ok;
    logic [LANES-1:0]  mask;
    logic [CNT_W-1:0]  cnt_use;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q   <= CTL_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            ctl_q   <= ctl_in;
            addr_q  <= addr_in;
            wdata_q <= wdata_in;
        end
    end

    assign sel_ok  = (ctl_q.sel_n == 3'b000);
    assign mask    = lane_mask(ctl_q.all_n, ctl_q.lane_en_n, ctl_q.lane_n);
    assign cnt_use = ctl_q.step_n ? cnt_q : CNT_W'(cnt_q + 1'b1);

    always_comb begin
        act_d   = act_q;
        base_d  = base_q;
        cnt_d   = cnt_q;
        ilv_d   = ilv_q;
        op      = OP_IDLE;
        op_addr = addr_q;
        if (!ctl_q.p_n && sel_ok) begin
            op     = OP_READ;
            act_d  = 1'b1;
            base_d = addr_q;
            cnt_d  = '0;
            ilv_d  = ctl_q.ilv;
        end else if (!ctl_q.c_n) begin
            if (sel_ok) begin
                op     = (|mask) ? OP_WRITE : OP_READ;
                act_d  = 1'b1;
                base_d = addr_q;
                cnt_d  = '0;
                ilv_d  = ctl_q.ilv;
            end else begin
                act_d  = 1'b0;
            end
        end else if (act_q) begin
            op      = (|mask) ? OP_WRITE : OP_READ;
            cnt_d   = cnt_use;
            op_addr = {base_q[AW-1:CNT_W], burst_low(base_q[CNT_W-1:0], cnt_use, ilv_q)};
        end
    end

    assign op_mask  = mask;
    assign op_wdata = wdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= 1'b0;
            base_q <= '0;
            cnt_q  <= '0;
            ilv_q  <= 1'b0;
        end else begin
            act_q  <= act_d;
            base_q <= base_d;
            cnt_q  <= cnt_d;
            ilv_q  <= ilv_d;
        end
    end

endmodule

// File: rtl/sram_array.sv
module sram_array
    import sram_pkg::*;
#(
    parameter int unsigned AW = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  op_e              op,
    input  logic [AW-1:0]    op_addr,
    input  logic [LANES-1:0] op_mask,
    input  logic [DW-1:0]    op_wdata,
    output op_e              rd_op,
    output logic [DW-1:0]    rd_data
);

    localparam int unsigned DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];
        logic [LANE_W-1:0] lane_rd;

        always_ff @(posedge clk) begin
            if (op == OP_WRITE && op_mask[g])
                lane_mem[op_addr] <= op_wdata[g*LANE_W +: LANE_W];
            lane_rd <= lane_mem[op_addr];
        end

        assign rd_data[g*LANE_W +: LANE_W] = lane_rd;
    end

    always_ff @(posedge clk) begin
        if (rst) rd_op <= OP_IDLE;
        else     rd_op <= op;
    end

endmodule

// File: rtl/sram_outreg.sv
module sram_outreg
    import sram_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  op_e           rd_op,
    input  logic [DW-1:0] rd_data,
    output logic [DW-1:0] dout,
    output logic          oe
);

    logic desel_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            dout       <= '0;
            oe         <= 1'b0;
            desel_prev <= 1'b1;
        end else begin
            unique case (rd_op)
                OP_READ: begin
                    dout       <= rd_data;
                    oe         <= 1'b1;
                    desel_prev <= 1'b0;
                end
                OP_WRITE: begin
                    oe         <= 1'b0;
                    desel_prev <= 1'b0;
                end
                default: begin
                    if (desel_prev) oe <= 1'b0;
                    desel_prev <= 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import sram_pkg::*;
#(
    parameter int unsigned AW = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    input  logic             strb_proc_n,
    input  logic             strb_ctl_n,
    input  logic             step_n,
    input  logic             wr_all_n,
    input  logic             lane_wr_en_n,
    input  logic [LANES-1:0] lane_sel_n,
    input  logic             order_ilv,
    input  logic             sel0_n,
    input  logic             sel1_n,
    input  logic             sel2_n,
    output logic [DW-1:0]    rdata,
    output logic             rdata_oe
);

    ctl_t             ctl_in;
    op_e              op, rd_op;
    logic [AW-1:0]    op_addr;
    logic [LANES-1:0] op_mask;
    logic [DW-1:0]    op_wdata, rd_data;

    assign ctl_in = '{p_n: strb_proc_n, c_n: strb_ctl_n, step_n: step_n,
                      all_n: wr_all_n, lane_en_n: lane_wr_en_n, lane_n: lane_sel_n,
                      ilv: order_ilv, sel_n: {sel2_n, sel1_n, sel0_n}};

    sram_ctrl #(.AW(AW)) u_ctrl (
        .clk(clk), .rst(rst), .ctl_in(ctl_in), .addr_in(addr), .wdata_in(wdata),
        .op(op), .op_addr(op_addr), .op_mask(op_mask), .op_wdata(op_wdata)
    );

    sram_array #(.AW(AW)) u_array (
        .clk(clk), .rst(rst), .op(op), .op_addr(op_addr), .op_mask(op_mask),
        .op_wdata(op_wdata), .rd_op(rd_op), .rd_data(rd_data)
    );

    sram_outreg u_out (
        .clk(clk), .rst(rst), .rd_op(rd_op), .rd_data(rd_data),
        .dout(rdata), .oe(rdata_oe)
    );

endmodule

// File: rtl/sram_chk.sv
module sram_chk
    import sram_pkg::*;
#(
    parameter int unsigned AW = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             strb_proc_n,
    input logic             strb_ctl_n,
    input logic             wr_all_n,
    input logic             sel0_n,
    input logic             sel1_n,
    input logic             sel2_n,
    input logic [DW-1:0]    rdata,
    input logic             rdata_oe
);

    logic sel_all, rd_open, desel, wr_open;
    assign sel_all = !sel0_n && !sel1_n && !sel2_n;
    assign rd_open = !strb_proc_n && sel_all;
    assign desel   = !strb_ctl_n && !sel_all;
    assign wr_open = strb_proc_n && !strb_ctl_n && sel_all && !wr_all_n;

    // R12
    reset_state_chk: assert property (@(posedge clk) rst |=> (!rdata_oe && rdata == '0));

    // R2
    proc_read_chk: assert property (@(posedge clk) disable iff (rst)
        rd_open |=> ##2 rdata_oe);

    // R11
    write_off_chk: assert property (@(posedge clk) disable iff (rst)
        wr_open |=> ##2 !rdata_oe);

    // R11
    desel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (desel && $past(rd_open) && !$past(rst)) |=> ##2 (rdata_oe && $stable(rdata)));

    // R11
    desel_off_chk: assert property (@(posedge clk) disable iff (rst)
        (desel && $past(desel)) |=> ##2 !rdata_oe);

endmodule

bind burst_sram sram_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst(rst), .strb_proc_n(strb_proc_n), .strb_ctl_n(strb_ctl_n),
    .wr_all_n(wr_all_n), .sel0_n(sel0_n), .sel1_n(sel1_n), .sel2_n(sel2_n),
    .rdata(rdata), .rdata_oe(rdata_oe)
);

// File: tb/test_burst_sram.sv
module test_burst_sram;

    localparam int AW = 6;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [35:0]   wdata = '0;
    logic          strb_proc_n = 1'b1, strb_ctl_n = 1'b1, step_n = 1'b1;
    logic          wr_all_n = 1'b1, lane_wr_en_n = 1'b1, order_ilv = 1'b0;
    logic [3:0]    lane_sel_n = 4'hF;
    logic          sel0_n = 1'b1, sel1_n = 1'b1, sel2_n = 1'b1;
    logic [35:0]   rdata;
    logic          rdata_oe;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    burst_sram #(.AW(AW)) i_burst_sram (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata),
        .strb_proc_n(strb_proc_n), .strb_ctl_n(strb_ctl_n), .step_n(step_n),
        .wr_all_n(wr_all_n), .lane_wr_en_n(lane_wr_en_n), .lane_sel_n(lane_sel_n),
        .order_ilv(order_ilv), .sel0_n(sel0_n), .sel1_n(sel1_n), .sel2_n(sel2_n),
        .rdata(rdata), .rdata_oe(rdata_oe)
    );

    // reference model state
    logic [35:0]   ref_mem [DEPTH];
    logic          m_act = 1'b0, m_ilv = 1'b0, m_oe = 1'b0, m_prevd = 1'b1;
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_cnt = '0;
    logic [35:0]   m_data = '0;
    logic          p_oe [3];
    logic [35:0]   p_d  [3];
    string         p_tag[3];

    function automatic logic [35:0] pat(input int a, input int salt);
        logic [35:0] v;
        v = {4'(salt), 8'(a * 7 + 3), 24'(a * 40503 + salt * 977) ^ 24'hA5C3E1};
        return v;
    endfunction

    task automatic cyc(input logic p_n, input logic c_n, input logic s_n, input logic ga_n,
                       input logic bw_n, input logic [3:0] bs_n, input logic ilv,
                       input logic [2:0] cs_n, input logic [AW-1:0] a,
                       input logic [35:0] d, input string tag);
        logic sel, wr, rd;
        logic [3:0] mk;
        logic [AW-1:0] ea;
        // model: decode from the requirements
        sel = (cs_n == 3'b000);
        mk  = !ga_n ? 4'hF : (!bw_n ? ~bs_n : 4'h0);
        wr = 1'b0; rd = 1'b0; ea = a;
        if (!p_n && sel) begin
            rd = 1'b1; m_act = 1'b1; m_base = a; m_cnt = 2'd0; m_ilv = ilv;
        end else if (!c_n) begin
            if (sel) begin
                wr = (mk != 0); rd = !wr; m_act = 1'b1; m_base = a; m_cnt = 2'd0; m_ilv = ilv;
            end else m_act = 1'b0;
        end else if (m_act) begin
            if (!s_n) m_cnt = m_cnt + 2'd1;
            ea = {m_base[AW-1:2], m_ilv ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt)};
            wr = (mk != 0); rd = !wr;
        end
        if (wr) begin
            for (int l = 0; l < 4; l++)
                if (mk[l]) ref_mem[ea][l*9 +: 9] = d[l*9 +: 9];
            m_oe = 1'b0; m_prevd = 1'b0;
        end else if (rd) begin
            m_oe = 1'b1; m_data = ref_mem[ea]; m_prevd = 1'b0;
        end else begin
            if (m_prevd) m_oe = 1'b0;
            m_prevd = 1'b1;
        end
        p_oe[2] = p_oe[1]; p_d[2] = p_d[1]; p_tag[2] = p_tag[1];
        p_oe[1] = p_oe[0]; p_d[1] = p_d[0]; p_tag[1] = p_tag[0];
        p_oe[0] = m_oe;    p_d[0] = m_data; p_tag[0] = tag;
        strb_proc_n = p_n; strb_ctl_n = c_n; step_n = s_n; wr_all_n = ga_n;
        lane_wr_en_n = bw_n; lane_sel_n = bs_n; order_ilv = ilv;
        {sel2_n, sel1_n, sel0_n} = cs_n; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (rdata_oe !== p_oe[2]) begin
            failures++;
            $display("FAIL %s oe actual=%0b expected=%0b", p_tag[2], rdata_oe, p_oe[2]);
        end else if (p_oe[2] && rdata !== p_d[2]) begin
            failures++;
            $display("FAIL %s data actual=%h expected=%h", p_tag[2], rdata, p_d[2]);
        end
    endtask

    task automatic rd_open(input int a, input logic ilv, input string tag);
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, ilv, 3'b000, AW'(a), 36'h0, tag);
    endtask

    task automatic nxt(input logic s_n, input logic ga_n, input logic bw_n,
                       input logic [3:0] bs_n, input logic [35:0] d, input string tag);
        cyc(1'b1, 1'b1, s_n, ga_n, bw_n, bs_n, 1'b0, 3'b000, '0, d, tag);
    endtask

    task automatic ctl_open(input int a, input logic ga_n, input logic bw_n,
                            input logic [3:0] bs_n, input logic [35:0] d, input string tag);
        cyc(1'b1, 1'b0, 1'b1, ga_n, bw_n, bs_n, 1'b0, 3'b000, AW'(a), d, tag);
    endtask

    task automatic desel(input string tag);
        cyc(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 1'b0, 3'b001, '0, 36'h0, tag);
    endtask

    initial begin
        for (int i = 0; i < 3; i++) begin p_oe[i] = 1'b0; p_d[i] = '0; p_tag[i] = "R12"; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (rdata_oe !== 1'b0 || rdata !== 36'h0) begin
            failures++;
            $display("FAIL R12 reset actual=%0b/%h expected=0/0", rdata_oe, rdata);
        end
        rst = 1'b0;

        // R10 / R5: fill every word with write-all bursts, linear order
        for (int b = 0; b < DEPTH / 4; b++) begin
            ctl_open(4 * b, 1'b0, 1'b1, 4'hF, pat(4 * b, 1), "R10");
            for (int i = 1; i < 4; i++) nxt(1'b0, 1'b0, 1'b1, 4'hF, pat(4 * b + i, 1), "R5");
        end

        // R1 R2 R6 R7 R8: read bursts from every start in both orders
        for (int o = 0; o < 2; o++)
            for (int a = 0; a < DEPTH; a++) begin
                rd_open(a, o[0], o ? "R8" : "R7");
                for (int i = 1; i < 4; i++) nxt(1'b0, 1'b1, 1'b1, 4'hF, 36'h0, o ? "R8" : "R7");
            end

        // R6: suspend repeats the word
        rd_open(13, 1'b0, "R6");
        nxt(1'b1, 1'b1, 1'b1, 4'hF, 36'h0, "R6");
        nxt(1'b1, 1'b1, 1'b1, 4'hF, 36'h0, "R6");
        nxt(1'b0, 1'b1, 1'b1, 4'hF, 36'h0, "R6");
        nxt(1'b1, 1'b1, 1'b1, 4'hF, 36'h0, "R6");

        // R9: every lane mask, read back
        for (int m = 1; m < 16; m++) begin
            ctl_open(16 + m, 1'b1, 1'b0, ~4'(m), pat(m, 9), "R9");
            rd_open(16 + m, 1'b0, "R9");
        end
        ctl_open(33, 1'b1, 1'b1, 4'h0, pat(33, 5), "R9");
        rd_open(33, 1'b0, "R9");

        // R10: write-all overrides lane controls
        ctl_open(40, 1'b0, 1'b1, 4'hF, pat(40, 7), "R10");
        ctl_open(41, 1'b0, 1'b0, 4'b1110, pat(41, 7), "R10");
        rd_open(40, 1'b0, "R10");
        rd_open(41, 1'b0, "R10");

        // R2: read-only strobe with write controls
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'h0, 1'b0, 3'b000, AW'(50), pat(50, 11), "R2");
        rd_open(50, 1'b0, "R2");
        // R4: both strobes
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 1'b0, 3'b000, AW'(51), pat(51, 11), "R4");
        rd_open(51, 1'b0, "R4");

        // R3: ignored strobe continues, then deselects via the other strobe
        rd_open(8, 1'b0, "R3");
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'hF, 1'b0, 3'b010, AW'(60), 36'h0, "R3");
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 1'b0, 3'b100, AW'(60), 36'h0, "R3");
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, 1'b0, 3'b100, AW'(60), 36'h0, "R3");

        // R11: deselect hold and turn-off, write slots off
        rd_open(5, 1'b0, "R11");
        desel("R11");
        desel("R11");
        desel("R11");
        rd_open(6, 1'b1, "R11");
        nxt(1'b1, 1'b0, 1'b1, 4'hF, pat(6, 13), "R11");
        desel("R11");
        desel("R11");
        rd_open(6, 1'b0, "R1");
        desel("R11");
        desel("R11");
        desel("R11");
        desel("R11");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule